// File: doc/BRIEF.md
# Thermal Alarm Event Generator

This block watches a stream of signed temperature samples and decides when a thermal alarm line should be active. Each sample that arrives with its valid strobe is compared against three programmable limits: an upper and a lower bound that together form an alarm window, and a higher critical limit. The result is kept in three status flags. A flag set by a rising crossing falls back only after the temperature drops below its limit minus a programmable hysteresis. The below-window flag works the mirror way: it sets only once the sample falls below the lower bound minus the hysteresis, and it clears once the sample is back at or above the lower bound.

The alarm line runs in one of two modes. In the level-following mode it tracks the flags. In the latched mode it captures a newly raised flag and holds until software writes a clear. A critical-only option narrows the watched set to the critical flag. The output polarity, an output enable and a low-power halt are all selectable. Two sticky lock bits protect the limits and the output setup from later writes.

The converter that produces the samples and the serial register interface sit outside the block. Register writes arrive as one-cycle strobes that share a common data word.

Top module: `thermal_event_gen`

## Requirements
- R1: After reset all three status flags read 0, every limit and the hysteresis are 0, the configuration is level-following, active-low and disabled, and `alarm_o` is 1 (inactive).
- R2: Limits are 11-bit two's complement values in `wr_data[10:0]` with a step of 0.25 °C. Samples are 13-bit two's complement values with a step of 0.125 °C. A sample strictly above the upper limit sets `stat_above`, and a sample strictly above the critical limit sets `stat_crit`.
- R3: `stat_above` and `stat_crit` stay set while a sample is at or above their limit minus the hysteresis, and clear below it. The hysteresis code is written in `wr_data[1:0]`: 0 selects 0 °C, 1 selects 1.5 °C, 2 selects 3 °C and 3 selects 6 °C.
- R4: `stat_below` sets when a sample is below the lower limit minus the hysteresis, and clears when a sample is at or above the lower limit.
- R5: In level-following mode (config bit 0 = 0) with output enabled (bit 2 = 1), the alarm is active exactly while any watched flag is set.
- R6: With critical-only set (bit 3 = 1), only `stat_crit` can drive the alarm. The window flags still update.
- R7: In latched mode (bit 0 = 1) the alarm becomes active when a watched flag newly sets, and it stays active after the flags clear. It returns to inactive only after a configuration write with bit 4 = 1.
- R8: Switching from level-following to latched mode while the alarm is active because of a flag that is already set makes the alarm inactive.
- R9: Config bit 1 selects the polarity (1 = active-high, 0 = active-low). Changing it changes `alarm_o` on the cycle after the write, including during shutdown.
- R10: With bit 2 = 0 the alarm is held inactive, while the status flags keep following the samples.
- R11: Bit 6 (window lock) and bit 7 (critical lock) are sticky until reset. The window lock blocks writes to the upper and lower limits, and the critical lock blocks writes to the critical limit. Either lock blocks writes to the hysteresis and to config bits 0, 1, 2, 3 and 5. Under a lock, shutdown (bit 8) may be cleared but not set.
- R12: While shutdown (bit 8) is set, samples are ignored and the flags hold their values. With bit 5 = 1 the alarm is inactive; with bit 5 = 0 it keeps its last state.
- R13: After shutdown is cleared the alarm stays inactive until a new sample has been evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_vld | input | 1 | Sample strobe, one cycle per sample |
| samp_temp | input | 13 | Signed sample, 0.125 °C per step |
| wr_upper | input | 1 | Write strobe for the upper limit |
| wr_lower | input | 1 | Write strobe for the lower limit |
| wr_crit | input | 1 | Write strobe for the critical limit |
| wr_hyst | input | 1 | Write strobe for the hysteresis code |
| wr_cfg | input | 1 | Write strobe for the configuration bits |
| wr_data | input | 16 | Data shared by all write strobes |
| alarm_o | output | 1 | Alarm output level after polarity |
| stat_crit | output | 1 | Above-critical flag |
| stat_above | output | 1 | Above-window flag |
| stat_below | output | 1 | Below-window flag |

## Verification
A corrupted flag register shows at the status pins right after the next sample and at `alarm_o` one clock later. A bad hysteresis band only shows when a sample lands between a limit and that limit minus the hysteresis, so the stimulus keeps many samples near each boundary. A stuck interrupt latch or stale-sample marker shows only after a mode change, a clear or a shutdown exit. Those moments are driven directly and the output is checked within three cycles of each one.

// File: rtl/tev_pkg.sv
// Shared widths, configuration bit positions and helpers for the
// thermal event generator. Assumes temperature LSB is half the limit LSB.
package tev_pkg;
    localparam int TEMP_W = 13;
    localparam int LIM_W  = 11;
    localparam int DATA_W = 16;
    localparam int HYS_W  = 2;
    localparam int HYS_UW = 6;

    localparam int B_MODE     = 0;
    localparam int B_POL      = 1;
    localparam int B_EN       = 2;
    localparam int B_CRITONLY = 3;
    localparam int B_CLR      = 4;
    localparam int B_SLEEP    = 5;
    localparam int B_WLOCK    = 6;
    localparam int B_CLOCK    = 7;
    localparam int B_SHDN     = 8;

    typedef struct packed {
        logic crit_lock;
        logic win_lock;
        logic shdn;
        logic sleep_off;
        logic crit_only;
        logic en;
        logic pol_high;
        logic mode_int;
    } tev_cfg_t;

    // Hysteresis code to temperature LSB units (0, 1.5, 3, 6 degrees)
    function automatic logic [HYS_UW-1:0] hyst_units(input logic [HYS_W-1:0] code);
        logic [HYS_UW-1:0] r;
        r = (code == '0) ? '0 : HYS_UW'(6'd12 << (code - 1'b1));
        return r;
    endfunction
endpackage

// File: rtl/tev_regs.sv
// Limit, hysteresis and configuration registers with lock protection.
// Assumes write strobes are single-cycle; limits leave aligned to the
// temperature resolution and sign-extended to TW bits.
module tev_regs
    import tev_pkg::*;
#(
    parameter int TW = TEMP_W,
    parameter int LW = LIM_W,
    parameter int DW = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_upper,
    input  logic                 wr_lower,
    input  logic                 wr_crit,
    input  logic                 wr_hyst,
    input  logic                 wr_cfg,
    input  logic [DW-1:0]        wr_data,
    output logic signed [TW-1:0] upper_o,
    output logic signed [TW-1:0] lower_o,
    output logic signed [TW-1:0] crit_o,
    output logic        [TW-1:0] hyst_o,
    output tev_cfg_t             cfg_o,
    output logic                 clr_o
);
    localparam int ALIGN = 1;
    localparam int EXT   = TW - LW - ALIGN;

    logic [LW-1:0]    upper_q, lower_q, crit_q;
    logic [HYS_W-1:0] hyst_q;
    tev_cfg_t         cfg_q;
    logic             clr_q;
    logic             locked;

    assign locked = cfg_q.win_lock | cfg_q.crit_lock;

    // Register writes, gated by the lock bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            lower_q <= '0;
            crit_q  <= '0;
            hyst_q  <= '0;
            cfg_q   <= '0;
            clr_q   <= 1'b0;
        end else begin
            clr_q <= wr_cfg & wr_data[B_CLR];
            if (wr_upper && !cfg_q.win_lock)  upper_q <= wr_data[LW-1:0];
            if (wr_lower && !cfg_q.win_lock)  lower_q <= wr_data[LW-1:0];
            if (wr_crit  && !cfg_q.crit_lock) crit_q  <= wr_data[LW-1:0];
            if (wr_hyst  && !locked)          hyst_q  <= wr_data[HYS_W-1:0];
            if (wr_cfg) begin
                if (!locked) begin
                    cfg_q.mode_int  <= wr_data[B_MODE];
                    cfg_q.pol_high  <= wr_data[B_POL];
                    cfg_q.en        <= wr_data[B_EN];
                    cfg_q.crit_only <= wr_data[B_CRITONLY];
                    cfg_q.sleep_off <= wr_data[B_SLEEP];
                    cfg_q.shdn      <= wr_data[B_SHDN];
                end else begin
                    cfg_q.shdn      <= cfg_q.shdn & wr_data[B_SHDN];
                end
                cfg_q.win_lock  <= cfg_q.win_lock  | wr_data[B_WLOCK];
                cfg_q.crit_lock <= cfg_q.crit_lock | wr_data[B_CLOCK];
            end
        end
    end

    assign upper_o = {{EXT{upper_q[LW-1]}}, upper_q, {ALIGN{1'b0}}};
    assign lower_o = {{EXT{lower_q[LW-1]}}, lower_q, {ALIGN{1'b0}}};
    assign crit_o  = {{EXT{crit_q[LW-1]}},  crit_q,  {ALIGN{1'b0}}};
    assign hyst_o  = {{(TW-HYS_UW){1'b0}}, hyst_units(hyst_q)};
    assign cfg_o   = cfg_q;
    assign clr_o   = clr_q;

    a_r11_upper_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_upper && cfg_q.win_lock) |=> $stable(upper_q));
    a_r11_crit_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_crit && cfg_q.crit_lock) |=> $stable(crit_q));
    a_r11_no_shdn_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && locked && !cfg_q.shdn) |=> !cfg_q.shdn);
    a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.win_lock |=> cfg_q.win_lock);
endmodule

// File: rtl/tev_hyst_cmp.sv
// One threshold flag with hysteresis. FALLING=0: set above thr, clear below
// thr-hyst. FALLING=1: set below thr-hyst, clear at or above thr.
// Assumes hyst_i is non-negative; updates only when upd is high.
module tev_hyst_cmp #(
    parameter int TW      = 13,
    parameter bit FALLING = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic signed [TW-1:0] temp_i,
    input  logic signed [TW-1:0] thr_i,
    input  logic        [TW-1:0] hyst_i,
    output logic                 flag_o
);
    localparam int EW = TW + 1;

    logic signed [EW-1:0] t_e, thr_e, hys_e, band_e;
    logic                 flag_q, nxt;

    assign t_e    = {temp_i[TW-1], temp_i};
    assign thr_e  = {thr_i[TW-1], thr_i};
    assign hys_e  = {1'b0, hyst_i};
    assign band_e = thr_e - hys_e;

    if (FALLING) begin : g_fall
        // Below-window decision
        always_comb nxt = flag_q ? (t_e < thr_e) : (t_e < band_e);
        a_r4_fall_set: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && t_e < band_e) |=> flag_q);
    end else begin : g_rise
        // Above-limit decision
        always_comb nxt = flag_q ? (t_e >= band_e) : (t_e > thr_e);
        a_r2_rise_set: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && t_e > thr_e) |=> flag_q);
        a_r3_rise_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && t_e < band_e) |=> !flag_q);
    end

    // Flag register, updated on evaluated samples only
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (upd) flag_q <= nxt;
    end

    assign flag_o = flag_q;

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(flag_q));
endmodule

// File: rtl/tev_out.sv
// Alarm output stage: mode selection, interrupt latch, enable, shutdown
// behaviour, stale-sample guard and polarity. flags_i = {crit, above, below}.
module tev_out
    import tev_pkg::*;
#(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [NF-1:0] flags_i,
    input  tev_cfg_t      cfg_i,
    input  logic          clr_i,
    output logic          alarm_o
);
    logic [NF-1:0] mask, prev_q, new_bits;
    logic          latch_q, fresh_q, act_q, live;

    assign mask     = cfg_i.crit_only ? NF'(1 << (NF - 1)) : '1;
    assign new_bits = flags_i & ~prev_q & mask;
    assign live     = cfg_i.en & fresh_q &
                      (cfg_i.mode_int ? latch_q : |(flags_i & mask));

    // Edge memory, interrupt latch and stale-sample guard
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            latch_q <= 1'b0;
            fresh_q <= 1'b0;
        end else begin
            prev_q <= flags_i;
            if (clr_i || !cfg_i.mode_int) latch_q <= 1'b0;
            else if (|new_bits)          latch_q <= 1'b1;
            if (cfg_i.shdn)  fresh_q <= 1'b0;
            else if (upd)    fresh_q <= 1'b1;
        end
    end

    // Active state, frozen or dropped during shutdown
    always_ff @(posedge clk) begin
        if (!rst_n)          act_q <= 1'b0;
        else if (cfg_i.shdn) act_q <= cfg_i.sleep_off ? 1'b0 : act_q;
        else                 act_q <= live;
    end

    assign alarm_o = cfg_i.pol_high ? act_q : ~act_q;

    a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.en && !cfg_i.shdn) |=> !act_q);
    a_r12_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.shdn && cfg_i.sleep_off) |=> !act_q);
    a_r12_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.shdn && !cfg_i.sleep_off) |=> $stable(act_q));
    a_r13_stale: assert property (@(posedge clk) disable iff (!rst_n)
        (!fresh_q && !cfg_i.shdn) |=> !act_q);
endmodule

// File: rtl/thermal_event_gen.sv
// Thermal alarm event generator top: registers, three hysteresis
// comparators and the output stage. Samples are ignored during shutdown.
module thermal_event_gen
    import tev_pkg::*;
#(
    parameter int TW = TEMP_W,
    parameter int LW = LIM_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          samp_vld,
    input  logic [TW-1:0] samp_temp,
    input  logic          wr_upper,
    input  logic          wr_lower,
    input  logic          wr_crit,
    input  logic          wr_hyst,
    input  logic          wr_cfg,
    input  logic [DW-1:0] wr_data,
    output logic          alarm_o,
    output logic          stat_crit,
    output logic          stat_above,
    output logic          stat_below
);
    localparam int NF = 3;

    logic signed [TW-1:0] upper, lower, crit;
    logic        [TW-1:0] hyst;
    tev_cfg_t             cfg;
    logic                 clr, upd;
    logic        [NF-1:0] flags;
    logic signed [TW-1:0] thr [NF];

    assign upd    = samp_vld & ~cfg.shdn;
    assign thr[0] = lower;
    assign thr[1] = upper;
    assign thr[2] = crit;

    tev_regs #(.TW(TW), .LW(LW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_upper(wr_upper), .wr_lower(wr_lower), .wr_crit(wr_crit),
        .wr_hyst(wr_hyst), .wr_cfg(wr_cfg), .wr_data(wr_data),
        .upper_o(upper), .lower_o(lower), .crit_o(crit),
        .hyst_o(hyst), .cfg_o(cfg), .clr_o(clr)
    );

    for (genvar i = 0; i < NF; i++) begin : g_cmp
        tev_hyst_cmp #(.TW(TW), .FALLING(i == 0)) u_cmp (
            .clk(clk), .rst_n(rst_n), .upd(upd),
            .temp_i(samp_temp), .thr_i(thr[i]), .hyst_i(hyst),
            .flag_o(flags[i])
        );
    end

    tev_out #(.NF(NF)) u_out (
        .clk(clk), .rst_n(rst_n), .upd(upd), .flags_i(flags),
        .cfg_i(cfg), .clr_i(clr), .alarm_o(alarm_o)
    );

    assign stat_below = flags[0];
    assign stat_above = flags[1];
    assign stat_crit  = flags[2];
endmodule

// File: tb/thermal_event_gen_tb.sv
module thermal_event_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_vld = 1'b0;
    logic [12:0] samp_temp = '0;
    logic        wr_upper = 1'b0, wr_lower = 1'b0, wr_crit = 1'b0;
    logic        wr_hyst = 1'b0, wr_cfg = 1'b0;
    logic [15:0] wr_data = '0;
    logic        alarm_o, stat_crit, stat_above, stat_below;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    thermal_event_gen u_dut (
        .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp_temp(samp_temp),
        .wr_upper(wr_upper), .wr_lower(wr_lower), .wr_crit(wr_crit),
        .wr_hyst(wr_hyst), .wr_cfg(wr_cfg), .wr_data(wr_data),
        .alarm_o(alarm_o), .stat_crit(stat_crit), .stat_above(stat_above),
        .stat_below(stat_below)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // sel: 0 upper, 1 lower, 2 crit, 3 hyst, 4 cfg
    task automatic wr(input int sel, input logic [15:0] d);
        @(negedge clk);
        wr_data  = d;
        wr_upper = (sel == 0);
        wr_lower = (sel == 1);
        wr_crit  = (sel == 2);
        wr_hyst  = (sel == 3);
        wr_cfg   = (sel == 4);
        @(negedge clk);
        {wr_upper, wr_lower, wr_crit, wr_hyst, wr_cfg} = '0;
        settle();
    endtask

    // Limit in whole degrees, written in 0.25 degree steps
    task automatic wr_deg(input int sel, input int deg);
        wr(sel, 16'(deg * 4));
    endtask

    // Sample in eighths of a degree
    task automatic samp(input int eighths);
        @(negedge clk);
        samp_temp = 13'(eighths);
        samp_vld  = 1'b1;
        @(negedge clk);
        samp_vld  = 1'b0;
        settle();
    endtask

    function automatic logic m_rise(logic cur, int t, int thr, int hy);
        return cur ? (t >= thr - hy) : (t > thr);
    endfunction

    function automatic logic m_fall(logic cur, int t, int thr, int hy);
        return cur ? (t < thr) : (t < thr - hy);
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic ma, mb, mc;
        int   t, hy;
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1 alarm", alarm_o, 1'b1);
        chk("R1 crit", stat_crit, 1'b0);
        chk("R1 above", stat_above, 1'b0);
        chk("R1 below", stat_below, 1'b0);

        wr_deg(0, 80); wr_deg(1, 10); wr_deg(2, 95);
        wr(4, 16'h004);
        samp(200);
        chk("R5 idle alarm", alarm_o, 1'b1);
        samp(641);
        chk("R2 above set", stat_above, 1'b1);
        chk("R5 alarm active", alarm_o, 1'b0);
        samp(640);
        chk("R3 stays at limit", stat_above, 1'b1);
        wr(3, 16'h2);
        samp(624);
        chk("R3 inside band", stat_above, 1'b1);
        samp(615);
        chk("R3 below band", stat_above, 1'b0);
        chk("R5 alarm released", alarm_o, 1'b1);
        samp(768);
        chk("R2 crit set", stat_crit, 1'b1);
        wr(4, 16'h00C);
        samp(720);
        chk("R3 crit cleared", stat_crit, 1'b0);
        chk("R6 window still set", stat_above, 1'b1);
        chk("R6 crit-only alarm", alarm_o, 1'b1);
        samp(200);
        samp(72);
        chk("R4 not yet below", stat_below, 1'b0);
        samp(48);
        chk("R4 below set", stat_below, 1'b1);
        samp(72);
        chk("R4 below held", stat_below, 1'b1);
        wr(4, 16'h004);
        chk("R5 below drives alarm", alarm_o, 1'b0);
        wr(4, 16'h005);
        chk("R8 switch to latched", alarm_o, 1'b1);
        samp(80);
        chk("R4 below cleared", stat_below, 1'b0);
        samp(48);
        chk("R7 latched set", alarm_o, 1'b0);
        samp(200);
        chk("R7 held after clear of flag", alarm_o, 1'b0);
        wr(4, 16'h015);
        chk("R7 cleared by write", alarm_o, 1'b1);
        wr(4, 16'h007);
        chk("R9 active-high idle", alarm_o, 1'b0);
        wr(4, 16'h005);
        chk("R9 active-low idle", alarm_o, 1'b1);
        wr(4, 16'h000);
        samp(768);
        chk("R10 disabled alarm", alarm_o, 1'b1);
        chk("R10 flag updates", stat_crit, 1'b1);
        samp(200);
        wr(4, 16'h004);
        samp(768);
        chk("R5 crit alarm", alarm_o, 1'b0);
        wr(4, 16'h104);
        chk("R12 frozen alarm", alarm_o, 1'b0);
        samp(200);
        chk("R12 sample ignored", stat_crit, 1'b1);
        wr(4, 16'h106);
        chk("R9 polarity in shutdown", alarm_o, 1'b1);
        wr(4, 16'h126);
        chk("R12 sleep deasserts", alarm_o, 1'b0);
        wr(4, 16'h004);
        chk("R13 stale after exit", alarm_o, 1'b1);
        samp(768);
        chk("R13 fresh sample", alarm_o, 1'b0);

        // Random phase, level-following mode, hysteresis 1.5 degrees
        samp(200);
        wr(3, 16'h1);
        hy = 12;
        ma = 1'b0; mb = 1'b0; mc = 1'b0;
        for (int i = 0; i < 80; i++) begin
            if ($urandom_range(0, 2) == 0)
                t = $urandom_range(0, 1040) - 160;
            else
                case ($urandom_range(0, 2))
                    0: t = 640 + $urandom_range(0, 30) - 18;
                    1: t = 80 + $urandom_range(0, 30) - 18;
                    default: t = 760 + $urandom_range(0, 30) - 18;
                endcase
            samp(t);
            ma = m_rise(ma, t, 640, hy);
            mc = m_rise(mc, t, 760, hy);
            mb = m_fall(mb, t, 80, hy);
            chk("R2 R3 random above", stat_above, ma);
            chk("R3 random crit", stat_crit, mc);
            chk("R4 random below", stat_below, mb);
            chk("R5 random alarm", alarm_o, ~(ma | mb | mc));
        end

        // R11 locks
        samp(200);
        wr(4, 16'h144);
        samp(768);
        chk("R11 shutdown with lock", stat_crit, 1'b0);
        wr(4, 16'h044);
        samp(768);
        chk("R11 shutdown clearable", stat_crit, 1'b1);
        wr(4, 16'h144);
        samp(200);
        chk("R11 shutdown not settable", stat_crit, 1'b0);
        wr_deg(0, 20);
        samp(400);
        chk("R11 upper write blocked", stat_above, 1'b0);
        wr_deg(2, 100);
        samp(776);
        chk("R11 crit write allowed", stat_crit, 1'b0);
        chk("R11 above at 97", stat_above, 1'b1);
        wr(4, 16'h046);
        chk("R11 polarity blocked", alarm_o, 1'b0);
        wr(4, 16'h0C4);
        wr_deg(2, 50);
        samp(480);
        chk("R11 crit write blocked", stat_crit, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule